// File: doc/BRIEF.md
# Raster Timing Generator for Parallel RGB Panels

This block produces the raster timing for a parallel RGB display: horizontal sync, vertical sync, a data-enable strobe, the x/y position of the current pixel inside the visible area, a vertical-blanking flag with a one-cycle rising-edge pulse for frame-boundary update logic, and a pixel colour that carries a constant background value over the visible area. It runs on the pixel clock and advances one pixel per cycle while its enable input is high.

The raster shape is given by cumulative boundaries on each axis, each stored as a count minus one. The sync limit is the sync length minus one. The back-porch limit is sync plus back porch minus one. The active limit adds the visible size to that. The total limit adds the front porch as well. This form lets the comparators work on the raw counter with no adders. The sync, data-enable and pixel-clock outputs each have their own polarity select.

Top module: `rgb_timing_gen`

## Requirements
- R1: While `enable` is low, both raster counters are held at zero. While `enable` is low, `hsync`, `vsync` and `de` sit at their inactive levels, `xPos`/`yPos` are 0 and `pixRgb` is 0.
- R2: With `enable` high, the column counter advances once per clock. It returns to 0 on the clock after it reaches `hTotal`, so a line lasts `hTotal`+1 clocks.
- R3: The line counter advances only when the column counter wraps. It returns to 0 after line `vTotal`, so a frame lasts `vTotal`+1 lines.
- R4: The horizontal sync is active while the column is at most `hSyncEnd`. This gives a pulse of `hSyncEnd`+1 clocks at the start of each line.
- R5: The vertical sync is active on the lines whose index is at most `vSyncEnd`.
- R6: `de` is active only when both of these hold: the column is greater than `hBpEnd` and at most `hActEnd`, and the line is greater than `vBpEnd` and at most `vActEnd`.
- R7: Each of `hsPolHigh`, `vsPolHigh` and `dePolHigh` selects the level of its output: 1 means active high and 0 means active low.
- R8: During `de`, `xPos` equals column − `hBpEnd` − 1 and `yPos` equals line − `vBpEnd` − 1. Outside `de`, both are 0.
- R9: `pixRgb` equals `bgRgb` (bits 23:16 red, 15:8 green, 7:0 blue) while `de` is active. Otherwise `pixRgb` is 0, which is black.
- R10: `vBlank` is 1 whenever the line is outside (`vBpEnd`, `vActEnd`], and also while disabled. `vBlankRise` is high for exactly the one cycle in which `vBlank` goes from 0 to 1.
- R11: `pixClkOut` follows `clk` when `clkPolRise` is 1 and is its inverse when `clkPolRise` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the raster; low holds counters at zero |
| hSyncEnd | input | TW | Horizontal sync length − 1 |
| hBpEnd | input | TW | Sync + back porch − 1 (columns) |
| hActEnd | input | TW | Sync + back porch + width − 1 |
| hTotal | input | TW | Full line length − 1 |
| vSyncEnd | input | TW | Vertical sync lines − 1 |
| vBpEnd | input | TW | Sync + back porch − 1 (lines) |
| vActEnd | input | TW | Sync + back porch + height − 1 |
| vTotal | input | TW | Full frame height − 1 |
| hsPolHigh | input | 1 | Horizontal sync active high when 1 |
| vsPolHigh | input | 1 | Vertical sync active high when 1 |
| dePolHigh | input | 1 | Data enable active high when 1 |
| clkPolRise | input | 1 | Pixel clock output non-inverted when 1 |
| bgRgb | input | 24 | Background colour, R in 23:16, G in 15:8, B in 7:0 |
| hsync | output | 1 | Horizontal sync at selected polarity |
| vsync | output | 1 | Vertical sync at selected polarity |
| de | output | 1 | Data enable at selected polarity |
| xPos | output | TW | Column within visible area |
| yPos | output | TW | Line within visible area |
| pixRgb | output | 24 | Pixel colour: background when visible, else black |
| vBlank | output | 1 | Line is outside the visible rows |
| vBlankRise | output | 1 | One-cycle pulse at start of vertical blanking |
| pixClkOut | output | 1 | Pixel clock at selected edge polarity |

## Verification
The bench keeps the default width of 12 bits. It programs a tiny raster: a 10-clock line with a 2-clock sync and a 4-pixel visible span, and a 6-line frame with 3 visible rows. With a frame of only 60 cycles, every wrap, sync edge, window boundary and blanking transition comes up many times within a short run. The raster is replayed under four polarity and colour combinations. Directed cases then cover the idle state and a shutdown in the middle of a visible pixel, which must force blanking and emit the rising-edge pulse.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  // per-cycle step commands from the controller to the counters
  typedef struct packed {
    logic run;       // raster is enabled
    logic lineEnd;   // column counter is at its last value
    logic frameEnd;  // last column of the last line
  } rtg_step_t;
endpackage

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
  import rtg_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          enable,
  input  logic [TW-1:0] hCnt,
  input  logic [TW-1:0] vCnt,
  input  logic [TW-1:0] hTotal,
  input  logic [TW-1:0] vTotal,
  output rtg_step_t     step
);
  logic hLast;
  logic vLast;

  // a ">=" compare keeps the counters bounded if a limit shrinks mid-frame
  assign hLast = (hCnt >= hTotal);
  assign vLast = (vCnt >= vTotal);

  always_comb begin
    step.run      = enable;
    step.lineEnd  = enable & hLast;
    step.frameEnd = enable & hLast & vLast;
  end
endmodule

// File: rtl/rtg_count.sv
module rtg_count
  import rtg_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rtg_step_t     step,
  input  logic [TW-1:0] hTotal,
  output logic [TW-1:0] hCnt,
  output logic [TW-1:0] vCnt
);
  localparam logic [TW-1:0] ONE = TW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (!step.run) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (step.lineEnd) begin
      hCnt <= '0;
      vCnt <= step.frameEnd ? '0 : vCnt + ONE;
    end else begin
      hCnt <= hCnt + ONE;
    end
  end

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step.run |=> (hCnt == '0 && vCnt == '0));

  // R2
  hwrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step.run && hCnt >= hTotal) |=> (hCnt == '0));

  // R3
  vhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step.run && hCnt < hTotal) |=> $stable(vCnt));
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode #(
  parameter int TW = 12,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] hCnt,
  input  logic [TW-1:0] vCnt,
  input  logic [TW-1:0] hSyncEnd,
  input  logic [TW-1:0] hBpEnd,
  input  logic [TW-1:0] hActEnd,
  input  logic [TW-1:0] vSyncEnd,
  input  logic [TW-1:0] vBpEnd,
  input  logic [TW-1:0] vActEnd,
  input  logic          hsPolHigh,
  input  logic          vsPolHigh,
  input  logic          dePolHigh,
  input  logic [CW-1:0] bgRgb,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [TW-1:0] xPos,
  output logic [TW-1:0] yPos,
  output logic [CW-1:0] pixRgb,
  output logic          vBlank,
  output logic          vBlankRise
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic hsAct, vsAct, hVis, vVis, deAct, vBlankQ;

  assign hsAct = run && (hCnt <= hSyncEnd);
  assign vsAct = run && (vCnt <= vSyncEnd);
  assign hVis  = (hCnt > hBpEnd) && (hCnt <= hActEnd);
  assign vVis  = (vCnt > vBpEnd) && (vCnt <= vActEnd);
  assign deAct = run && hVis && vVis;

  // polarity: active level equals the select bit
  assign hsync = hsPolHigh ? hsAct : ~hsAct;
  assign vsync = vsPolHigh ? vsAct : ~vsAct;
  assign de    = dePolHigh ? deAct : ~deAct;

  assign xPos   = deAct ? (hCnt - hBpEnd - ONE) : '0;
  assign yPos   = deAct ? (vCnt - vBpEnd - ONE) : '0;
  assign pixRgb = deAct ? bgRgb : '0;

  assign vBlank = ~(run && vVis);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vBlankQ <= 1'b1;
    else        vBlankQ <= vBlank;
  end

  assign vBlankRise = vBlank & ~vBlankQ;

  // R1
  sync_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (hsync == ~hsPolHigh && vsync == ~vsPolHigh && de == ~dePolHigh));

  // R8
  coord_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de != dePolHigh) |-> (xPos == '0 && yPos == '0));

  // R9
  rgb_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de != dePolHigh) |-> (pixRgb == '0));

  // R10
  rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vBlankRise |=> !vBlankRise);

  // R6
  de_in_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de == dePolHigh) |-> !vBlank);
endmodule

// File: rtl/rgb_timing_gen.sv
module rgb_timing_gen
  import rtg_pkg::*;
#(
  parameter int TW = 12,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [TW-1:0] hSyncEnd,
  input  logic [TW-1:0] hBpEnd,
  input  logic [TW-1:0] hActEnd,
  input  logic [TW-1:0] hTotal,
  input  logic [TW-1:0] vSyncEnd,
  input  logic [TW-1:0] vBpEnd,
  input  logic [TW-1:0] vActEnd,
  input  logic [TW-1:0] vTotal,
  input  logic          hsPolHigh,
  input  logic          vsPolHigh,
  input  logic          dePolHigh,
  input  logic          clkPolRise,
  input  logic [CW-1:0] bgRgb,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [TW-1:0] xPos,
  output logic [TW-1:0] yPos,
  output logic [CW-1:0] pixRgb,
  output logic          vBlank,
  output logic          vBlankRise,
  output logic          pixClkOut
);
  rtg_step_t     step;
  logic [TW-1:0] hCnt;
  logic [TW-1:0] vCnt;

  rtg_ctrl #(.TW(TW)) u_ctrl (
    .enable (enable),
    .hCnt   (hCnt),
    .vCnt   (vCnt),
    .hTotal (hTotal),
    .vTotal (vTotal),
    .step   (step)
  );

  rtg_count #(.TW(TW)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .hTotal (hTotal),
    .hCnt   (hCnt),
    .vCnt   (vCnt)
  );

  rtg_decode #(.TW(TW), .CW(CW)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (step.run),
    .hCnt       (hCnt),
    .vCnt       (vCnt),
    .hSyncEnd   (hSyncEnd),
    .hBpEnd     (hBpEnd),
    .hActEnd    (hActEnd),
    .vSyncEnd   (vSyncEnd),
    .vBpEnd     (vBpEnd),
    .vActEnd    (vActEnd),
    .hsPolHigh  (hsPolHigh),
    .vsPolHigh  (vsPolHigh),
    .dePolHigh  (dePolHigh),
    .bgRgb      (bgRgb),
    .hsync      (hsync),
    .vsync      (vsync),
    .de         (de),
    .xPos       (xPos),
    .yPos       (yPos),
    .pixRgb     (pixRgb),
    .vBlank     (vBlank),
    .vBlankRise (vBlankRise)
  );

  // R11: output edge select
  assign pixClkOut = clkPolRise ? clk : ~clk;
endmodule

// File: tb/sim_rgb_timing_gen.sv
module sim_rgb_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 12;
  // raster: line 10 clocks (sync 2, bp 2, act 4, fp 2); frame 6 lines (sync 1, bp 1, act 3, fp 1)
  localparam int HT = 10, VT = 6;
  // {hsPol, vsPol, dePol, clkPol, bg[23:0]}
  localparam logic [27:0] CFG [4] = '{
    {4'b1111, 24'hFF8040},
    {4'b0000, 24'h123456},
    {4'b1010, 24'hA5A5A5},
    {4'b0101, 24'h00FF00}
  };

  logic clk = 0, rst_n = 0, enable = 0;
  logic hsPolHigh = 1, vsPolHigh = 1, dePolHigh = 1, clkPolRise = 1;
  logic [23:0] bgRgb = '0;
  logic hsync, vsync, de, vBlank, vBlankRise, pixClkOut;
  logic [TW-1:0] xPos, yPos;
  logic [23:0] pixRgb;
  int nTests = 0, nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rgb_timing_gen #(.TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .hSyncEnd(12'd1), .hBpEnd(12'd3), .hActEnd(12'd7), .hTotal(12'd9),
    .vSyncEnd(12'd0), .vBpEnd(12'd1), .vActEnd(12'd4), .vTotal(12'd5),
    .hsPolHigh(hsPolHigh), .vsPolHigh(vsPolHigh), .dePolHigh(dePolHigh),
    .clkPolRise(clkPolRise), .bgRgb(bgRgb),
    .hsync(hsync), .vsync(vsync), .de(de), .xPos(xPos), .yPos(yPos),
    .pixRgb(pixRgb), .vBlank(vBlank), .vBlankRise(vBlankRise), .pixClkOut(pixClkOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkIdle(input string tag);
    chk({tag, " R1 hsync"}, hsync, !hsPolHigh);
    chk({tag, " R1 vsync"}, vsync, !vsPolHigh);
    chk({tag, " R1 de"}, de, !dePolHigh);
    chk({tag, " R1 xy"}, {xPos, yPos}, 0);
    chk({tag, " R1 rgb"}, pixRgb, 0);
    chk({tag, " R10 vBlank idle"}, vBlank, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    bit prevVb;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chkIdle("reset");
    chk("R10 no pulse after reset", vBlankRise, 0);

    // table walk: one frame plus a few lines per configuration
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      enable = 0;
      {hsPolHigh, vsPolHigh, dePolHigh, clkPolRise} = CFG[c][27:24];
      bgRgb = CFG[c][23:0];
      @(negedge clk); #1;
      chkIdle("cfg idle");
      @(negedge clk);
      enable = 1;
      prevVb = 1;
      for (int n = 1; n <= HT * VT + 15; n++) begin
        int hc, vc;
        bit hsA, vsA, deA, vb;
        @(posedge clk); #1;
        hc = n % HT;
        vc = (n / HT) % VT;
        hsA = (hc <= 1);
        vsA = (vc <= 0);
        vb  = !(vc > 1 && vc <= 4);
        deA = (hc > 3 && hc <= 7) && !vb;
        chk("R2 R4 R7 hsync", hsync, hsPolHigh ? hsA : !hsA);
        chk("R3 R5 R7 vsync", vsync, vsPolHigh ? vsA : !vsA);
        chk("R6 R7 de", de, dePolHigh ? deA : !deA);
        chk("R8 xPos", xPos, deA ? hc - 4 : 0);
        chk("R8 yPos", yPos, deA ? vc - 2 : 0);
        chk("R9 pixRgb", pixRgb, deA ? bgRgb : 24'h0);
        chk("R10 vBlank", vBlank, vb);
        chk("R10 vBlankRise", vBlankRise, vb && !prevVb);
        chk("R11 pixClkOut", pixClkOut, clkPolRise);
        prevVb = vb;
      end
    end

    // directed: shut down on a visible pixel (n=25: column 5, line 2)
    @(negedge clk);
    enable = 0;
    {hsPolHigh, vsPolHigh, dePolHigh, clkPolRise} = 4'b1111;
    bgRgb = 24'hC0FFEE;
    @(negedge clk);
    enable = 1;
    repeat (25) @(posedge clk);
    #1;
    chk("R6 visible before stop", de, 1);
    chk("R8 x before stop", xPos, 1);
    @(negedge clk);
    enable = 0;
    #1;
    chk("R1 de drops at stop", de, 0);
    chk("R9 black at stop", pixRgb, 0);
    chk("R10 pulse at stop", vBlankRise, 1);
    @(posedge clk); #1;
    chk("R10 pulse one cycle", vBlankRise, 0);
    chkIdle("after stop");
    // R11 inverted edge seen at low phase of clk
    clkPolRise = 0;
    @(negedge clk); #1;
    chk("R11 inverted low phase", pixClkOut, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule